// File: doc/BRIEF.md
# FIFO DMA request generator

This block sits between the transmit and receive FIFOs of a serial controller and the DMA engine that moves their words. It watches the fill level of each FIFO and the per-direction enables, and raises a burst request and a single-word request for each direction. The DMA engine answers every request with a one-cycle acknowledge, and the request then falls in the next cycle.

Burst requests follow two watermarks. The receive side asks for a burst once the FIFO holds a full burst, that is at least the receive watermark plus one. The transmit side asks for a burst while its level has dropped to the transmit watermark or below. The transmit single request stands while the FIFO has room for one word. On the receive side, a transfer whose length is not a whole number of bursts leaves a tail that never reaches the watermark. An idle timer covers this case: once the receive FIFO has held a partial burst untouched for a programmed number of cycles, the timer raises a sticky single request, so that the DMA engine drains the tail one word at a time.

Top module: `fifo_dma_req`

## Requirements
- R1: While `rst` is high at a clock edge, all four request outputs are low after that edge.
- R2: `dma_en` bit 0 enables the receive side and bit 1 the transmit side. A disabled direction has both of its requests low one cycle later, and a pending receive single request is withdrawn too.
- R3: With the receive side enabled, `rx_breq` is high in the cycle after one in which `rx_level` is at least `rx_wmark`+1 and no burst acknowledge hits a raised `rx_breq`. Otherwise it is low.
- R4: With the transmit side enabled, `tx_breq` is high in the cycle after one in which `tx_level` is at most `tx_wmark` and no acknowledge hits a raised `tx_breq`. Otherwise it is low.
- R5: With the transmit side enabled, `tx_sreq` is high in the cycle after one in which `tx_level` is below the FIFO depth (64) and no acknowledge hits a raised `tx_sreq`. At full depth it is low.
- R6: An acknowledge taken while its request is high drives that request low in the next cycle. The request may rise again one cycle later if its condition still holds. An acknowledge taken while its request is low has no effect.
- R7: `tmo_cfg` bits 15:0 hold the threshold T, bit 16 enables the idle counter and bit 18 enables the single requests. A cycle qualifies when the receive side is enabled, bit 16 is set, `rx_level` is between 1 and `rx_wmark` inclusive, and there is no `rx_push`, no `rx_pop` and no accepted `rx_sack`. After T+1 consecutive qualifying cycles, `rx_sreq` rises at the end of the last one. With T=0 it rises after the first.
- R8: A push, a pop, an accepted `rx_sack`, or any non-qualifying cycle restarts the count at zero, so T+1 further qualifying cycles are needed.
- R9: Once raised, `rx_sreq` stays high until it is acknowledged or the receive side is disabled, whatever the receive level does, even when `rx_breq` rises alongside it.
- R10: With `tmo_cfg` bit 18 clear, `rx_sreq` never rises.
- R11: A push in the cycle the count would expire wins: `rx_sreq` stays low and counting starts over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dma_en | input | 2 | Bit 0 enables receive DMA, bit 1 enables transmit DMA |
| tx_level | input | 7 | Words held in the transmit FIFO |
| rx_level | input | 7 | Words held in the receive FIFO |
| tx_wmark | input | 6 | Transmit watermark: burst request at or below this level |
| rx_wmark | input | 6 | Receive burst size minus one |
| tmo_cfg | input | 32 | Idle timer: threshold 15:0, count enable 16, single enable 18 |
| rx_push | input | 1 | A word entered the receive FIFO this cycle |
| rx_pop | input | 1 | A word left the receive FIFO this cycle |
| tx_back | input | 1 | Acknowledge of the transmit burst request |
| tx_sack | input | 1 | Acknowledge of the transmit single request |
| rx_back | input | 1 | Acknowledge of the receive burst request |
| rx_sack | input | 1 | Acknowledge of the receive single request |
| tx_breq | output | 1 | Transmit burst request |
| tx_sreq | output | 1 | Transmit single request |
| rx_breq | output | 1 | Receive burst request |
| rx_sreq | output | 1 | Receive single request |

## Verification
Two receive-side events can meet in one cycle: the idle count reaching its threshold, and a word being pushed. The bench holds a partial level for exactly the threshold count and then pushes on the cycle the request would have risen. It expects `rx_sreq` to stay low and a full new count to follow. A second overlap raises the level to a full burst while a single request is pending, and the bench expects both receive requests high together until each gets its own acknowledge. A cycle-accurate behavioural model in the bench judges every output on every clock.

// File: rtl/fdr_pkg.sv
package fdr_pkg;

    // Control bit positions that the DMA side decodes
    localparam int DMA_RX_BIT     = 0;
    localparam int DMA_TX_BIT     = 1;
    localparam int TMO_THR_W      = 16;
    localparam int TMO_CNT_EN_BIT = 16;
    localparam int TMO_SGL_EN_BIT = 18;

    // Level-driven request channels
    typedef enum int {
        CH_TX_BURST  = 0,
        CH_TX_SINGLE = 1,
        CH_RX_BURST  = 2
    } chan_e;
    localparam int N_LVL_CH = 3;

    // Decoded idle-timer controls
    typedef struct packed {
        logic                 sgl_en;
        logic                 cnt_en;
        logic [TMO_THR_W-1:0] thr;
    } tmo_cfg_t;

    function automatic tmo_cfg_t tmo_decode(input logic [31:0] raw);
        tmo_cfg_t c;
        c.sgl_en = raw[TMO_SGL_EN_BIT];
        c.cnt_en = raw[TMO_CNT_EN_BIT];
        c.thr    = raw[TMO_THR_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/fdr_req_chan.sv
// One registered request that follows a level condition and drops for a
// cycle after an accepted acknowledge.
module fdr_req_chan (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic ack,
    output logic req
);
    logic hit;

    always_comb hit = ack && req;

    always_ff @(posedge clk) begin
        if (rst) req <= 1'b0;
        else     req <= cond && !hit;
    end
endmodule

// File: rtl/fdr_rx_tmo.sv
// Idle timer for a partial receive burst and its sticky single request.
module fdr_rx_tmo
    import fdr_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_en,
    input  tmo_cfg_t         cfg,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] burst_sz,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             sack,
    output logic             sreq
);
    logic [TMO_THR_W-1:0] cnt_q, cnt_d;
    logic                 qual, restart, fire, ack_hit;

    always_comb begin
        ack_hit = sack && sreq;
        qual    = rx_en && cfg.cnt_en && (rx_level != '0) && (rx_level < burst_sz);
        restart = !qual || rx_push || rx_pop || ack_hit;
        fire    = !restart && (cnt_q == cfg.thr);
        if (restart)   cnt_d = '0;
        else if (fire) cnt_d = cnt_q;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sreq  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (!rx_en)     sreq <= 1'b0;
            else if (sreq)  sreq <= !sack;
            else            sreq <= fire && cfg.sgl_en;
        end
    end
endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req
    import fdr_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int WM_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       dma_en,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [WM_W-1:0]  tx_wmark,
    input  logic [WM_W-1:0]  rx_wmark,
    input  logic [31:0]      tmo_cfg,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             tx_back,
    input  logic             tx_sack,
    input  logic             rx_back,
    input  logic             rx_sack,
    output logic             tx_breq,
    output logic             tx_sreq,
    output logic             rx_breq,
    output logic             rx_sreq
);
    logic                rx_en, tx_en;
    logic [LVL_W-1:0]    burst_sz;
    tmo_cfg_t            tcfg;
    logic [N_LVL_CH-1:0] ch_cond, ch_ack, ch_req;
    logic                unused_tmo_bits;

    always_comb begin
        rx_en    = dma_en[DMA_RX_BIT];
        tx_en    = dma_en[DMA_TX_BIT];
        burst_sz = LVL_W'(rx_wmark) + 1'b1;
        tcfg     = tmo_decode(tmo_cfg);

        ch_cond[CH_TX_BURST]  = tx_en && (tx_level <= LVL_W'(tx_wmark));
        ch_cond[CH_TX_SINGLE] = tx_en && (tx_level < LVL_W'(DEPTH));
        ch_cond[CH_RX_BURST]  = rx_en && (rx_level >= burst_sz);

        ch_ack[CH_TX_BURST]   = tx_back;
        ch_ack[CH_TX_SINGLE]  = tx_sack;
        ch_ack[CH_RX_BURST]   = rx_back;
    end

    assign unused_tmo_bits = ^{tmo_cfg[31:19], tmo_cfg[17]};

    for (genvar g = 0; g < N_LVL_CH; g++) begin : g_chan
        fdr_req_chan i_chan (
            .clk  (clk),
            .rst  (rst),
            .cond (ch_cond[g]),
            .ack  (ch_ack[g]),
            .req  (ch_req[g])
        );
    end

    fdr_rx_tmo #(.LVL_W(LVL_W)) i_tmo (
        .clk      (clk),
        .rst      (rst),
        .rx_en    (rx_en),
        .cfg      (tcfg),
        .rx_level (rx_level),
        .burst_sz (burst_sz),
        .rx_push  (rx_push),
        .rx_pop   (rx_pop),
        .sack     (rx_sack),
        .sreq     (rx_sreq)
    );

    assign tx_breq = ch_req[CH_TX_BURST];
    assign tx_sreq = ch_req[CH_TX_SINGLE];
    assign rx_breq = ch_req[CH_RX_BURST];
endmodule

// File: rtl/fifo_dma_req_chk.sv
module fifo_dma_req_chk #(
    parameter int DEPTH = 64,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int WM_W  = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       dma_en,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [WM_W-1:0]  tx_wmark,
    input logic [WM_W-1:0]  rx_wmark,
    input logic [31:0]      tmo_cfg,
    input logic             rx_push,
    input logic             rx_pop,
    input logic             tx_back,
    input logic             tx_sack,
    input logic             rx_back,
    input logic             rx_sack,
    input logic             tx_breq,
    input logic             tx_sreq,
    input logic             rx_breq,
    input logic             rx_sreq
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!tx_breq && !tx_sreq && !rx_breq && !rx_sreq));

    // R2
    tx_off_chk: assert property (@(posedge clk) disable iff (rst)
        !dma_en[1] |=> (!tx_breq && !tx_sreq));

    // R2
    rx_off_chk: assert property (@(posedge clk) disable iff (rst)
        !dma_en[0] |=> (!rx_breq && !rx_sreq));

    // R3
    rx_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_en[0] && rx_level > LVL_W'(rx_wmark) && !(rx_breq && rx_back)) |=> rx_breq);

    // R4
    tx_burst_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_en[1] && tx_level <= LVL_W'(tx_wmark) && !(tx_breq && tx_back)) |=> tx_breq);

    // R5
    tx_full_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_level == LVL_W'(DEPTH)) |=> !tx_sreq);

    // R6
    tx_burst_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_breq && tx_back) |=> !tx_breq);

    // R6
    tx_single_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_sreq && tx_sack) |=> !tx_sreq);

    // R6
    rx_burst_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_breq && rx_back) |=> !rx_breq);

    // R6
    rx_single_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_sreq && rx_sack) |=> !rx_sreq);

    // R9
    rx_single_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_sreq && !rx_sack && dma_en[0]) |=> rx_sreq);

    // R10
    single_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!tmo_cfg[18] && !rx_sreq) |=> !rx_sreq);

    // R11
    push_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && !rx_sreq) |=> !rx_sreq);
endmodule

bind fifo_dma_req fifo_dma_req_chk #(.DEPTH(DEPTH)) i_chk (.*);

// File: tb/test_fifo_dma_req.sv
`timescale 1ns/1ps
module test_fifo_dma_req;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] dma_en = '0;
    logic [6:0] tx_level = '0, rx_level = '0;
    logic [5:0] tx_wmark = '0, rx_wmark = '0;
    logic [31:0] tmo_cfg = '0;
    logic rx_push = 0, rx_pop = 0, tx_back = 0, tx_sack = 0, rx_back = 0, rx_sack = 0;
    logic tx_breq, tx_sreq, rx_breq, rx_sreq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    // behavioural reference state
    bit m_tb, m_ts, m_rb, m_rs;
    int m_cnt;

    fifo_dma_req #(.DEPTH(DEPTH)) i_fifo_dma_req (.*);

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Reference model, advanced on every rising edge
    always @(posedge clk) begin
        int  thr;
        bit  qual, restart, fire, a_rs;
        cycles++;
        if (rst) begin
            m_tb = 0; m_ts = 0; m_rb = 0; m_rs = 0; m_cnt = 0;
        end else begin
            thr  = int'(tmo_cfg[15:0]);
            a_rs = rx_sack && m_rs;
            qual = dma_en[0] && tmo_cfg[16] && int'(rx_level) > 0
                   && int'(rx_level) < int'(rx_wmark) + 1;
            restart = !qual || rx_push || rx_pop || a_rs;
            fire    = !restart && (m_cnt == thr);
            if (!dma_en[0])  m_rs = 0;
            else if (m_rs)   m_rs = !rx_sack;
            else             m_rs = fire && tmo_cfg[18];
            if (restart)     m_cnt = 0;
            else if (!fire)  m_cnt = m_cnt + 1;
            m_tb = dma_en[1] && int'(tx_level) <= int'(tx_wmark) && !(tx_back && m_tb);
            m_ts = dma_en[1] && int'(tx_level) < DEPTH && !(tx_sack && m_ts);
            m_rb = dma_en[0] && int'(rx_level) >= int'(rx_wmark) + 1 && !(rx_back && m_rb);
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4 tx_breq model", tx_breq, m_tb);
            chk("R5 tx_sreq model", tx_sreq, m_ts);
            chk("R3 rx_breq model", rx_breq, m_rb);
            chk("R7 rx_sreq model", rx_sreq, m_rs);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R1 tx_breq in reset", tx_breq, 0);
        chk("R1 rx_sreq in reset", rx_sreq, 0);
        rst = 0;
        step(1);
        chk("R1 outputs after reset", tx_breq | tx_sreq | rx_breq | rx_sreq, 0);

        // Transmit side
        tx_wmark = 6'd31;
        step(1);
        chk("R2 tx disabled", tx_breq, 0);
        dma_en = 2'b10;
        step(1);
        chk("R4 tx burst at empty", tx_breq, 1);
        chk("R5 tx single at empty", tx_sreq, 1);
        tx_back = 1; tx_level = 7'd10;
        step(1);
        tx_back = 0;
        chk("R6 tx burst drops after ack", tx_breq, 0);
        step(1);
        chk("R6 tx burst re-evaluated", tx_breq, 1);
        tx_level = 7'd40;
        step(1);
        chk("R4 tx above watermark", tx_breq, 0);
        tx_back = 1; tx_level = 7'd5;
        step(1);
        tx_back = 0;
        chk("R6 stray tx ack ignored", tx_breq, 1);
        tx_level = 7'd64;
        step(1);
        chk("R5 tx single at full", tx_sreq, 0);
        tx_level = 7'd63;
        step(1);
        chk("R5 tx single one free", tx_sreq, 1);
        tx_sack = 1;
        step(1);
        tx_sack = 0;
        chk("R6 tx single drops after ack", tx_sreq, 0);
        for (int l = 0; l <= DEPTH; l++) begin
            tx_level = 7'(l);
            tx_back  = (l % 5 == 0);
            step(1);
        end
        tx_back = 0;
        tx_level = 7'd64;
        step(1);

        // Receive bursts
        dma_en = 2'b01;
        step(1);
        chk("R2 tx off clears requests", tx_breq | tx_sreq, 0);
        rx_wmark = 6'd15; rx_level = 7'd15;
        step(1);
        chk("R3 rx below burst", rx_breq, 0);
        rx_level = 7'd16;
        step(1);
        chk("R3 rx full burst", rx_breq, 1);
        rx_back = 1;
        step(1);
        rx_back = 0;
        chk("R6 rx burst drops after ack", rx_breq, 0);
        step(1);
        chk("R6 rx burst back", rx_breq, 1);

        // Idle timer, threshold 16
        tmo_cfg = 32'h0005_0010;
        rx_level = 7'd0;
        step(1);
        rx_level = 7'd5;
        step(16);
        chk("R7 no single before expiry", rx_sreq, 0);
        step(1);
        chk("R7 single at expiry", rx_sreq, 1);
        rx_level = 7'd3;
        step(5);
        chk("R9 single held", rx_sreq, 1);
        rx_level = 7'd16;
        step(1);
        chk("R9 single with burst", rx_sreq, 1);
        chk("R3 burst with single", rx_breq, 1);
        rx_level = 7'd3; rx_sack = 1; rx_pop = 1;
        step(1);
        rx_sack = 0; rx_pop = 0;
        chk("R6 rx single drops after ack", rx_sreq, 0);

        // Restart by a push
        rx_level = 7'd0;
        step(1);
        rx_level = 7'd5;
        step(10);
        rx_push = 1;
        step(1);
        rx_push = 0; rx_level = 7'd6;
        step(16);
        chk("R8 count restarted by push", rx_sreq, 0);
        step(1);
        chk("R8 expiry after full recount", rx_sreq, 1);
        rx_sack = 1; rx_pop = 1; rx_level = 7'd5;
        step(1);
        rx_sack = 0; rx_pop = 0;

        // Push on the expiry cycle
        rx_level = 7'd0;
        step(1);
        rx_level = 7'd5;
        step(16);
        rx_push = 1;
        step(1);
        rx_push = 0; rx_level = 7'd6;
        chk("R11 push beats expiry", rx_sreq, 0);
        step(17);
        chk("R11 later expiry", rx_sreq, 1);
        rx_sack = 1; rx_pop = 1; rx_level = 7'd5;
        step(1);
        rx_sack = 0; rx_pop = 0;

        // Single requests disabled
        tmo_cfg = 32'h0001_0010;
        rx_level = 7'd0;
        step(1);
        rx_level = 7'd5;
        step(40);
        chk("R10 single disabled", rx_sreq, 0);

        // Counter disabled
        tmo_cfg = 32'h0004_0010;
        step(40);
        chk("R7 counter disabled", rx_sreq, 0);

        // Zero threshold
        tmo_cfg = 32'h0005_0000;
        rx_level = 7'd0;
        step(1);
        rx_level = 7'd4;
        step(1);
        chk("R7 zero threshold", rx_sreq, 1);
        step(3);
        dma_en = 2'b00;
        step(1);
        chk("R2 rx off withdraws single", rx_sreq, 0);
        chk("R2 rx off burst", rx_breq, 0);
        step(2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule